// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sits on the host side of a byte-wide flash device that is reached through a control-latch port. A select line chooses the destination of each bus byte. When it is high, the byte loads a mode latch: clear, command phase, address phase or serial-clock phase. When it is low, the byte goes to the flash under the latched mode. A requester hands over one operation at a time with a valid/ready handshake. The operation is a serial read, a single-sector erase, or a sector program in rewrite or blank-sector flavour, with a two-byte sector address and a byte count. The sequencer then emits the complete byte sequence for that operation.

For programs and erases the block issues the start code and then reads the flash status on every cycle. Bit 7 serves as the busy/ready flag. Once ready, it inspects the error bit that belongs to the operation. On an error it issues a clear-status command. A programmable limit on consecutive busy polls ends a stuck operation with a timeout result. Every operation closes with a clear of the mode latch and a one-cycle done pulse carrying a 2-bit result.

Top module: `flashSeq`

## Requirements
- R1: After reset, reqReady is 1 and busWr, busRd, done and rdValid are 0.
- R2: Every accepted operation begins with six bus writes: latch 0x0F, latch 0x01, flash command, latch 0x03, flash address high byte, flash address low byte. The command depends on reqOp: 0 (read) sends 0x00, 1 (erase) sends 0x20, 2 (program rewrite) sends 0x11, 3 (program blank) sends 0x1F.
- R3: A read performs reqLen consecutive busRd cycles after the address. Each byte sampled from busIn appears on rdData with rdValid one cycle after its read strobe.
- R4: A program writes latch 0x04, then reqLen flash writes taken from wrData, each consumed with wrDataReady in the same cycle, then latch 0x01 and flash 0x40.
- R5: An erase writes latch 0x01 and flash 0xB0 directly after the address, with no data phase.
- R6: After a start code the block asserts busRd every cycle and makes no bus write while busIn bit 7 reads 0 (busy). Bit 7 at 1 (ready) ends polling.
- R7: When ready, a program reports result 1 if status bit 4 is set and an erase reports result 2 if status bit 5 is set. The other operation's error bit has no effect (result 0).
- R8: After a reported error the block writes latch 0x01 and flash 0x50 (clear status) before the closing clear.
- R9: If busy is seen on pollLimit consecutive polls, the result is 3 and the block closes without a clear-status command.
- R10: Each operation ends with a latch write of 0x0F in the cycle where done pulses for one cycle with the result. reqReady is 1 in the following cycle.
- R11: A program with reqLen 0 skips the data phase, so latch 0x04 is followed directly by latch 0x01.
- R12: While an operation is in progress reqReady is 0, and a held reqValid starts no second operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Operation request valid |
| reqReady | output | 1 | Sequencer idle, request taken when both high |
| reqOp | input | 2 | 0 read, 1 erase, 2 program rewrite, 3 program blank |
| reqAddr | input | 16 | Sector address, high byte sent first |
| reqLen | input | LEN_W | Data byte count for read or program |
| pollLimit | input | TO_W | Maximum consecutive busy polls |
| wrData | input | 8 | Program data byte from the source |
| wrDataReady | output | 1 | Program data byte consumed this cycle |
| rdData | output | 8 | Read data byte |
| rdValid | output | 1 | rdData valid |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 write error, 2 erase error, 3 timeout |
| busOut | output | 8 | Byte driven to latch or flash |
| busIn | input | 8 | Byte returned by flash (data or status) |
| latchSel | output | 1 | 1 routes busOut into the mode latch, 0 to the flash |
| busWr | output | 1 | Write strobe for busOut |
| busRd | output | 1 | Read strobe, busIn sampled at the clock edge |

## Verification
Counting the accepting edge as cycle 0, done appears in cycle n+7 for a read of n bytes and in cycle b+10 for an erase that answers busy b times. A program takes n+b+11 cycles, and a reported error adds two cycles for the clear-status pair. A timeout ends in cycle n+L+10 with L the poll limit. Each scenario task samples outputs at the falling edge, counts cycles from the accepting edge up to the first done, and compares that count with the formula. Afterwards it compares the full logged byte sequence and any read data against lists built from the requirements.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  typedef enum logic [1:0] {
    OP_READ       = 2'd0,
    OP_ERASE      = 2'd1,
    OP_PROG_RW    = 2'd2,
    OP_PROG_BLANK = 2'd3
  } opE;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_WERR = 2'd1,
    RES_EERR = 2'd2,
    RES_TMO  = 2'd3
  } resE;

  typedef enum logic [1:0] {
    BSRC_CONST = 2'd0,
    BSRC_AHI   = 2'd1,
    BSRC_ALO   = 2'd2,
    BSRC_WDATA = 2'd3
  } bsrcE;

  // strobes from control to datapath
  typedef struct packed {
    logic       capReq;
    logic       cntClr;
    logic       cntInc;
    logic       pollClr;
    logic       pollInc;
    logic       capRd;
    logic       setRes;
    resE        resCode;
    bsrcE       bsrc;
    logic [7:0] constByte;
  } dpCtlT;

  // mode-latch codes
  localparam logic [7:0] LATCH_CLEAR = 8'h0F;
  localparam logic [7:0] LATCH_CMD   = 8'h01;
  localparam logic [7:0] LATCH_ADDR  = 8'h03;
  localparam logic [7:0] LATCH_SCLK  = 8'h04;

  // flash command codes
  localparam logic [7:0] FCMD_READ     = 8'h00;
  localparam logic [7:0] FCMD_ERASE    = 8'h20;
  localparam logic [7:0] FCMD_PROG_RW  = 8'h11;
  localparam logic [7:0] FCMD_PROG_BLK = 8'h1F;
  localparam logic [7:0] FCMD_PROG_GO  = 8'h40;
  localparam logic [7:0] FCMD_ERASE_GO = 8'hB0;

endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter logic [7:0] CLR_STATUS = 8'h50
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  opE    reqOp,
  input  logic  lenZero,
  input  logic  lenLast,
  input  logic  pollExpire,
  input  logic  statReady,
  input  logic  statWErr,
  input  logic  statEErr,
  output logic  reqReady,
  output logic  busWr,
  output logic  busRd,
  output logic  latchSel,
  output logic  wrDataReady,
  output logic  done,
  output dpCtlT ctl
);

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_CMDL, S_CMD, S_ADDL, S_AHI, S_ALO, S_RDAT,
    S_SCL, S_WDAT, S_STL, S_GO, S_POLL, S_CSL, S_CSC, S_FIN
  } stateE;

  stateE state, stateNext;
  opE    opQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_READ;
    end else begin
      state <= stateNext;
      if (ctl.capReq) opQ <= reqOp;
    end
  end

  function automatic logic [7:0] cmdCode(opE op);
    case (op)
      OP_READ:    cmdCode = FCMD_READ;
      OP_ERASE:   cmdCode = FCMD_ERASE;
      OP_PROG_RW: cmdCode = FCMD_PROG_RW;
      default:    cmdCode = FCMD_PROG_BLK;
    endcase
  endfunction

  logic statErr;
  assign statErr = (opQ == OP_ERASE) ? statEErr : statWErr;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    reqReady    = 1'b0;
    busWr       = 1'b0;
    busRd       = 1'b0;
    latchSel    = 1'b0;
    wrDataReady = 1'b0;
    done        = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capReq = 1'b1;
          stateNext  = S_CLR;
        end
      end
      S_CLR:  begin busWr = 1'b1; latchSel = 1'b1; ctl.constByte = LATCH_CLEAR; stateNext = S_CMDL; end
      S_CMDL: begin busWr = 1'b1; latchSel = 1'b1; ctl.constByte = LATCH_CMD;   stateNext = S_CMD;  end
      S_CMD:  begin busWr = 1'b1; ctl.constByte = cmdCode(opQ);                 stateNext = S_ADDL; end
      S_ADDL: begin busWr = 1'b1; latchSel = 1'b1; ctl.constByte = LATCH_ADDR;  stateNext = S_AHI;  end
      S_AHI:  begin busWr = 1'b1; ctl.bsrc = BSRC_AHI; stateNext = S_ALO; end
      S_ALO: begin
        busWr      = 1'b1;
        ctl.bsrc   = BSRC_ALO;
        ctl.cntClr = 1'b1;
        case (opQ)
          OP_READ:  stateNext = lenZero ? S_FIN : S_RDAT;
          OP_ERASE: stateNext = S_STL;
          default:  stateNext = S_SCL;
        endcase
      end
      S_RDAT: begin
        busRd      = 1'b1;
        ctl.capRd  = 1'b1;
        ctl.cntInc = 1'b1;
        if (lenLast) stateNext = S_FIN;
      end
      S_SCL: begin
        busWr = 1'b1; latchSel = 1'b1; ctl.constByte = LATCH_SCLK;
        stateNext = lenZero ? S_STL : S_WDAT;
      end
      S_WDAT: begin
        busWr       = 1'b1;
        ctl.bsrc    = BSRC_WDATA;
        wrDataReady = 1'b1;
        ctl.cntInc  = 1'b1;
        if (lenLast) stateNext = S_STL;
      end
      S_STL: begin
        busWr = 1'b1; latchSel = 1'b1; ctl.constByte = LATCH_CMD;
        ctl.pollClr = 1'b1;
        stateNext = S_GO;
      end
      S_GO: begin
        busWr = 1'b1;
        ctl.constByte = (opQ == OP_ERASE) ? FCMD_ERASE_GO : FCMD_PROG_GO;
        stateNext = S_POLL;
      end
      S_POLL: begin
        busRd = 1'b1;
        if (statReady) begin
          if (statErr) begin
            ctl.setRes  = 1'b1;
            ctl.resCode = (opQ == OP_ERASE) ? RES_EERR : RES_WERR;
            stateNext   = S_CSL;
          end else begin
            stateNext = S_FIN;
          end
        end else if (pollExpire) begin
          ctl.setRes  = 1'b1;
          ctl.resCode = RES_TMO;
          stateNext   = S_FIN;
        end else begin
          ctl.pollInc = 1'b1;
        end
      end
      S_CSL: begin busWr = 1'b1; latchSel = 1'b1; ctl.constByte = LATCH_CMD; stateNext = S_CSC; end
      S_CSC: begin busWr = 1'b1; ctl.constByte = CLR_STATUS; stateNext = S_FIN; end
      S_FIN: begin
        busWr = 1'b1; latchSel = 1'b1; ctl.constByte = LATCH_CLEAR;
        done  = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady)); // R10

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POLL && !statReady && !pollExpire) |=> (busRd && !busWr)); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !reqReady); // R12

endmodule

// File: rtl/flashSeqDp.sv
module flashSeqDp
  import flashSeqPkg::*;
#(
  parameter int LEN_W = 12,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtlT            ctl,
  input  logic [15:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [TO_W-1:0]  pollLimit,
  input  logic [7:0]       wrData,
  input  logic [7:0]       busIn,
  output logic [7:0]       busOut,
  output logic             lenZero,
  output logic             lenLast,
  output logic             pollExpire,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output resE              result
);

  localparam int ADDR_W = 16;

  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  lenQ;
  logic [LEN_W-1:0]  cnt;
  logic [TO_W-1:0]   pollCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      lenQ    <= '0;
      cnt     <= '0;
      pollCnt <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
      result  <= RES_OK;
    end else begin
      if (ctl.capReq) begin
        addrQ  <= reqAddr;
        lenQ   <= reqLen;
        result <= RES_OK;
      end
      if (ctl.setRes) result <= ctl.resCode;
      if (ctl.cntClr)      cnt <= '0;
      else if (ctl.cntInc) cnt <= cnt + 1'b1;
      if (ctl.pollClr)      pollCnt <= '0;
      else if (ctl.pollInc) pollCnt <= pollCnt + 1'b1;
      rdValid <= ctl.capRd;
      if (ctl.capRd) rdData <= busIn;
    end
  end

  assign lenZero    = (lenQ == '0);
  assign lenLast    = ({1'b0, cnt} + 1'b1) == {1'b0, lenQ};
  assign pollExpire = ({1'b0, pollCnt} + 1'b1) >= {1'b0, pollLimit};

  always_comb begin
    case (ctl.bsrc)
      BSRC_AHI:   busOut = addrQ[ADDR_W-1:8];
      BSRC_ALO:   busOut = addrQ[7:0];
      BSRC_WDATA: busOut = wrData;
      default:    busOut = ctl.constByte;
    endcase
  end

  AST_POLL_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pollInc |-> (({1'b0, pollCnt} + 1'b1) < {1'b0, pollLimit})); // R9

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntInc |-> (cnt < lenQ)); // R3

endmodule

// File: rtl/flashSeq.sv
module flashSeq
  import flashSeqPkg::*;
#(
  parameter int         LEN_W      = 12,
  parameter int         TO_W       = 16,
  parameter logic [7:0] CLR_STATUS = 8'h50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [15:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [TO_W-1:0]  pollLimit,
  input  logic [7:0]       wrData,
  output logic             wrDataReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             done,
  output logic [1:0]       result,
  output logic [7:0]       busOut,
  input  logic [7:0]       busIn,
  output logic             latchSel,
  output logic             busWr,
  output logic             busRd
);

  dpCtlT ctl;
  logic  lenZero, lenLast, pollExpire;
  resE   resQ;

  flashSeqCtrl #(.CLR_STATUS(CLR_STATUS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(opE'(reqOp)),
    .lenZero(lenZero), .lenLast(lenLast), .pollExpire(pollExpire),
    .statReady(busIn[7]), .statWErr(busIn[4]), .statEErr(busIn[5]),
    .reqReady(reqReady), .busWr(busWr), .busRd(busRd), .latchSel(latchSel),
    .wrDataReady(wrDataReady), .done(done), .ctl(ctl)
  );

  flashSeqDp #(.LEN_W(LEN_W), .TO_W(TO_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqLen(reqLen),
    .pollLimit(pollLimit), .wrData(wrData), .busIn(busIn), .busOut(busOut),
    .lenZero(lenZero), .lenLast(lenLast), .pollExpire(pollExpire),
    .rdData(rdData), .rdValid(rdValid), .result(resQ)
  );

  assign result = resQ;

  AST_ACCEPT_OPENS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busWr && latchSel && busOut == LATCH_CLEAR)); // R2

  AST_DONE_CLOSES_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busWr && latchSel && busOut == LATCH_CLEAR)); // R10

  AST_RDVALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(busRd)); // R3

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd && wrDataReady)); // R4

endmodule

// File: tb/tb_flashSeq.sv
`timescale 1ns/1ps
module tb_flashSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [11:0] reqLen = 12'd0;
  logic [15:0] pollLimit = 16'd50;
  logic [7:0]  wrData;
  logic        wrDataReady;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        done;
  logic [1:0]  result;
  logic [7:0]  busOut;
  logic [7:0]  busIn;
  logic        latchSel, busWr, busRd;

  always #2.5 clk = ~clk;

  flashSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen), .pollLimit(pollLimit),
    .wrData(wrData), .wrDataReady(wrDataReady), .rdData(rdData), .rdValid(rdValid),
    .done(done), .result(result), .busOut(busOut), .busIn(busIn),
    .latchSel(latchSel), .busWr(busWr), .busRd(busRd)
  );

  int checks = 0;
  int errors = 0;

  // behavioural flash responder and bus logger
  logic       logClr = 1'b0;
  int         cfgBusy = 0;
  logic [7:0] cfgErr = 8'h00;
  logic [8:0] logMem [0:63];
  logic [7:0] rdMem  [0:63];
  int         logCnt = 0, rdCnt = 0, busyLeft = 0, busyViol = 0, wrIdx = 0, rdIdx = 0;
  logic [7:0] mode = 8'h0F, cmdReg = 8'hFF, status = 8'h80;

  assign busIn  = (cmdReg == 8'h00) ? (8'hA0 + 8'(rdIdx)) : ((busyLeft != 0) ? 8'h00 : status);
  assign wrData = 8'h30 + 8'(wrIdx);

  always @(posedge clk) begin
    if (logClr) begin
      logCnt <= 0; rdCnt <= 0; busyLeft <= 0; busyViol <= 0; wrIdx <= 0; rdIdx <= 0;
      status <= 8'h80; cmdReg <= 8'hFF; mode <= 8'h0F;
    end else begin
      if (busWr) begin
        if (logCnt < 64) logMem[logCnt] <= {latchSel, busOut};
        logCnt <= logCnt + 1;
        if (latchSel) mode <= busOut;
        else begin
          if (busyLeft != 0) busyViol <= busyViol + 1;
          if (mode == 8'h01) begin
            if (busOut == 8'h40 || busOut == 8'hB0) begin
              busyLeft <= cfgBusy;
              status   <= 8'h80 | cfgErr;
            end else if (busOut == 8'h50) status <= 8'h80;
            else begin
              cmdReg <= busOut;
              rdIdx  <= 0;
            end
          end
        end
      end
      if (busRd) begin
        if (busyLeft != 0) busyLeft <= busyLeft - 1;
        if (cmdReg == 8'h00) rdIdx <= rdIdx + 1;
      end
      if (wrDataReady) wrIdx <= wrIdx + 1;
      if (rdValid) begin
        if (rdCnt < 64) rdMem[rdCnt] <= rdData;
        rdCnt <= rdCnt + 1;
      end
    end
  end

  // expected sequence
  logic [8:0] expMem [0:63];
  int expCnt = 0;

  task automatic ex(input logic l, input logic [7:0] b);
    if (expCnt < 64) expMem[expCnt] = {l, b};
    expCnt++;
  endtask

  task automatic head(input logic [7:0] cmd, input logic [15:0] a);
    expCnt = 0;
    ex(1, 8'h0F); ex(1, 8'h01); ex(0, cmd); ex(1, 8'h03); ex(0, a[15:8]); ex(0, a[7:0]);
  endtask

  task automatic chk(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic chkSeq(input string req);
    int bad = -1;
    checks++;
    for (int i = 0; i < expCnt && i < 64; i++)
      if (bad < 0 && (i >= logCnt || logMem[i] !== expMem[i])) bad = i;
    if (logCnt != expCnt || bad >= 0) begin
      errors++;
      if (bad >= 0)
        $display("FAIL %s sequence entry %0d: actual %h expected %h (count %0d vs %0d)",
                 req, bad, logMem[bad], expMem[bad], logCnt, expCnt);
      else
        $display("FAIL %s sequence length: actual %0d expected %0d", req, logCnt, expCnt);
    end
  endtask

  int   cyc;
  logic [1:0] res;
  int   readyBad;
  logic readyAfter;

  task automatic runOp(input logic [1:0] op, input logic [15:0] a, input int len,
                       input int busy, input logic [7:0] err, input int limit, input int hold);
    @(negedge clk);
    cfgBusy = busy; cfgErr = err; pollLimit = 16'(limit); logClr = 1'b1;
    @(negedge clk);
    logClr = 1'b0;
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqLen = 12'(len);
    @(posedge clk);
    @(negedge clk);
    cyc = 1; readyBad = 0;
    reqValid = (hold > 0);
    while (!done && cyc < 3000) begin
      if (reqReady) readyBad++;
      @(negedge clk);
      cyc++;
      if (cyc > hold) reqValid = 1'b0;
    end
    reqValid = 1'b0;
    res = result;
    if (cyc >= 3000) chk("R10", 0, 1, "done never arrived");
    @(negedge clk);
    readyAfter = reqReady;
  endtask

  task automatic tReset();
    chk("R1", reqReady, 1, "reqReady after reset");
    chk("R1", {busWr, busRd, done, rdValid}, 0, "strobes after reset");
  endtask

  task automatic tRead();
    runOp(2'd0, 16'h1234, 4, 0, 8'h00, 50, 3);
    head(8'h00, 16'h1234); ex(1, 8'h0F);
    chkSeq("R2");
    chk("R10", cyc, 11, "read done latency");
    chk("R10", res, 0, "read result");
    chk("R10", readyAfter, 1, "reqReady after done");
    chk("R12", readyBad, 0, "reqReady while busy");
    chk("R3", rdCnt, 4, "read byte count");
    for (int i = 0; i < 4; i++) chk("R3", rdMem[i], 8'hA0 + i, "read data");
  endtask

  task automatic tErase();
    runOp(2'd1, 16'hBEEF, 0, 3, 8'h00, 50, 0);
    head(8'h20, 16'hBEEF); ex(1, 8'h01); ex(0, 8'hB0); ex(1, 8'h0F);
    chkSeq("R5");
    chk("R6", cyc, 13, "erase done latency");
    chk("R6", busyViol, 0, "flash writes while busy");
    chk("R5", res, 0, "erase result");
  endtask

  task automatic tProgRw();
    runOp(2'd2, 16'h0102, 3, 2, 8'h00, 50, 0);
    head(8'h11, 16'h0102); ex(1, 8'h04);
    ex(0, 8'h30); ex(0, 8'h31); ex(0, 8'h32);
    ex(1, 8'h01); ex(0, 8'h40); ex(1, 8'h0F);
    chkSeq("R4");
    chk("R4", cyc, 16, "program done latency");
    chk("R4", wrIdx, 3, "data bytes consumed");
    chk("R4", res, 0, "program result");
  endtask

  task automatic tProgWerr();
    runOp(2'd3, 16'h7F00, 2, 1, 8'h10, 50, 0);
    head(8'h1F, 16'h7F00); ex(1, 8'h04); ex(0, 8'h30); ex(0, 8'h31);
    ex(1, 8'h01); ex(0, 8'h40); ex(1, 8'h01); ex(0, 8'h50); ex(1, 8'h0F);
    chkSeq("R8");
    chk("R7", res, 1, "program write error result");
    chk("R8", cyc, 16, "error done latency");
  endtask

  task automatic tEraseErr();
    runOp(2'd1, 16'h0003, 0, 0, 8'h20, 50, 0);
    head(8'h20, 16'h0003); ex(1, 8'h01); ex(0, 8'hB0); ex(1, 8'h01); ex(0, 8'h50); ex(1, 8'h0F);
    chkSeq("R8");
    chk("R7", res, 2, "erase error result");
  endtask

  task automatic tEraseOtherBit();
    runOp(2'd1, 16'h0004, 0, 1, 8'h10, 50, 0);
    head(8'h20, 16'h0004); ex(1, 8'h01); ex(0, 8'hB0); ex(1, 8'h0F);
    chkSeq("R7");
    chk("R7", res, 0, "erase ignores write-error bit");
  endtask

  task automatic tTimeout();
    runOp(2'd2, 16'h0A0B, 1, 100, 8'h00, 4, 0);
    head(8'h11, 16'h0A0B); ex(1, 8'h04); ex(0, 8'h30); ex(1, 8'h01); ex(0, 8'h40); ex(1, 8'h0F);
    chkSeq("R9");
    chk("R9", res, 3, "timeout result");
    chk("R9", cyc, 15, "timeout done latency");
  endtask

  task automatic tZeroLen();
    runOp(2'd2, 16'h5555, 0, 0, 8'h00, 50, 0);
    head(8'h11, 16'h5555); ex(1, 8'h04); ex(1, 8'h01); ex(0, 8'h40); ex(1, 8'h0F);
    chkSeq("R11");
    chk("R11", wrIdx, 0, "no data consumed");
  endtask

  initial begin
    #10000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRead();
    tErase();
    tProgRw();
    tProgWerr();
    tEraseErr();
    tEraseOtherBit();
    tTimeout();
    tZeroLen();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule